// File: doc/BRIEF.md
# Clock Generator Startup Sequencer

This block is the control state machine of a PLL-based clock generator. It runs the device from reset through the configuration load and PLL lock acquisition. It then runs an optional automatic output synchronization and enters normal operation with the outputs enabled. While it runs it serves later sync requests and recovers from loss of lock. The configuration loader and the analog PLL are outside the block. Each one is reached through a simple handshake: a start strobe and a done input for the loader, and a request output and a lock input for the PLL.

A six-bit control word is written through a one-cycle write strobe. Two of its bits are active-low commands: a software reset and a software sync. They are acted on when written and are never stored. The other four bits are held settings: autostart, clock hold, sync mute and auto sync.

A device reset comes from the asynchronous power-on input or from the external active-low reset pin. The pin reset also returns the settings to their defaults and forces a new configuration load. A software reset takes the sequencer back through its reset state but leaves the settings and the configuration-loaded status alone, so no reload is started. Every pin is a plain level or strobe. No data moves through the block, so no valid/ready handshake is needed.

Top module: `clkgen_startup_seq`

## Requirements
- R1: While `por_n` is low, `cfg_start`, `pll_req`, `sync_out`, `out_en`, `out_mute` and `sysclk_vco` are 0 and `aon_osc_en` is 1. One cycle after `por_n` rises, `cfg_start` is high for exactly one cycle.
- R2: A low `ext_rst_n` holds the sequencer in reset with `pll_req` and `out_en` at 0 and restores the settings to their defaults. In the first cycle after it returns high, `cfg_start` pulses and a new configuration load begins.
- R3: A write with bit 5 equal to 0 (software reset, active low) puts the sequencer in reset in the next cycle. One cycle later it goes straight to lock acquisition or halt, with no `cfg_start`. The settings carried in that write are kept and are not returned to their defaults.
- R4: When `cfg_done` is seen during configuration, the sequencer goes to lock acquisition (`pll_req` = 1) if autostart is 1, and otherwise it halts with `pll_req` = 0. While halted, writing autostart to 1 raises `pll_req` two cycles after the write cycle.
- R5: When `pll_locked` is seen during lock acquisition after any reset, the sequencer enters a sync event if auto sync is 1, and otherwise goes directly to run. Both states drive `out_en` = 1.
- R6: A sync event drives `sync_out` high for exactly SYNC_LEN consecutive cycles. The sequencer then returns to run.
- R7: `out_mute` is 1 only during a sync event and only when sync mute is 1.
- R8: With clock hold 0, `sysclk_vco` is 1 and `aon_osc_en` is 0 in the run and sync states. With clock hold 1, or in any other state, `sysclk_vco` is 0 and `aon_osc_en` is 1.
- R9: In run, a rising edge on `sync_pin` or a write with bit 4 equal to 0 (software sync, active low) starts a sync event in the next cycle.
- R10: Sync requests made before the first run (during reset, halt, configuration or lock acquisition) are ignored, and so are requests made during a sync event. A pin held high causes no further event.
- R11: Loss of `pll_locked` in run or sync returns the sequencer to lock acquisition in the next cycle, with `out_en` = 0 and `pll_req` = 1. When lock returns, the sequencer goes to run without an automatic sync.
- R12: Control word bit positions and defaults: bit 0 autostart (default 1), bit 1 clock hold (0), bit 2 sync mute (1), bit 3 auto sync (1), bit 4 software sync active low, bit 5 software reset active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, sampled on the clock |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word write data |
| sync_pin | input | 1 | External sync request, acted on at its rising edge |
| cfg_done | input | 1 | Configuration loader finished |
| pll_locked | input | 1 | PLL lock indication |
| cfg_start | output | 1 | One-cycle configuration load start |
| pll_req | output | 1 | PLL calibration/lock request |
| sync_out | output | 1 | Output divider synchronization |
| out_en | output | 1 | Output drivers enabled |
| out_mute | output | 1 | Output drivers muted |
| sysclk_vco | output | 1 | System clock taken from the VCO path |
| aon_osc_en | output | 1 | Always-on oscillator enabled and selected |

## Verification
Every output is decoded from registered state. A stimulus sampled at one clock edge is therefore visible after that edge, except in two cases that take an extra cycle: a setting write acts on the following cycle, and a software reset shows its effect one cycle after the reset state. The bench drives inputs on the falling edge and samples on the next falling edge, after exactly the number of rising edges each result needs. It sweeps all sixteen combinations of the four settings. For each combination it works out the expected `pll_req`, sync length, mute and clock-select values from the setting bits.

// File: rtl/csq_pkg.sv
package csq_pkg;

  localparam int CTL_W        = 6;
  localparam int BIT_AUTOSTRT = 0;
  localparam int BIT_CLKHOLD  = 1;
  localparam int BIT_MUTE     = 2;
  localparam int BIT_AUTOSYNC = 3;
  localparam int BIT_SYNC_N   = 4;
  localparam int BIT_RST_N    = 5;

  typedef enum logic [2:0] {
    S_RESET  = 3'd0,
    S_CONFIG = 3'd1,
    S_HALT   = 3'd2,
    S_LOCK   = 3'd3,
    S_SYNC   = 3'd4,
    S_RUN    = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic auto_sync;
    logic sync_mute;
    logic clk_hold;
    logic autostart;
  } ctl_t;

  localparam ctl_t CTL_DEFAULT = '{auto_sync: 1'b1, sync_mute: 1'b1,
                                   clk_hold: 1'b0, autostart: 1'b1};

endpackage

// File: rtl/csq_ctl_reg.sv
module csq_ctl_reg
  import csq_pkg::*;
#(
  parameter int W = CTL_W
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         ext_rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output ctl_t         ctl,
  output logic         sw_rst_req,
  output logic         sw_sync_req
);

  // Command bits act on the write cycle only; the settings are held.
  assign sw_rst_req  = wr && !wdata[BIT_RST_N];
  assign sw_sync_req = wr && !wdata[BIT_SYNC_N];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctl <= CTL_DEFAULT;
    end else if (!ext_rst_n) begin
      ctl <= CTL_DEFAULT;
    end else if (wr) begin
      ctl.autostart <= wdata[BIT_AUTOSTRT];
      ctl.clk_hold  <= wdata[BIT_CLKHOLD];
      ctl.sync_mute <= wdata[BIT_MUTE];
      ctl.auto_sync <= wdata[BIT_AUTOSYNC];
    end
  end

  // R12 / R2: a pin reset leaves default settings behind it
  p_defaults_after_pin_r12: assert property (@(posedge clk) disable iff (!por_n)
    !ext_rst_n |=> (ctl == CTL_DEFAULT));

  // R12: a write outside reset is captured into the settings
  p_write_captured_r12: assert property (@(posedge clk) disable iff (!por_n)
    (wr && ext_rst_n) |=> (ctl.autostart == $past(wdata[BIT_AUTOSTRT])));

endmodule

// File: rtl/csq_sync_req.sv
module csq_sync_req (
  input  logic clk,
  input  logic por_n,
  input  logic pin,
  input  logic sw_req,
  output logic req
);

  logic pin_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pin_q <= 1'b0;
    else        pin_q <= pin;
  end

  assign req = (pin && !pin_q) || sw_req;

  // R10: a pin held high gives no request after its first cycle
  p_level_no_repeat_r10: assert property (@(posedge clk) disable iff (!por_n)
    (pin && $past(pin) && !sw_req) |-> !req);

endmodule

// File: rtl/csq_sync_timer.sv
module csq_sync_timer #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic load,
  output logic done
);

  localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           cnt <= '0;
    else if (load)        cnt <= LAST;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R6: the window count never leaves its range
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!por_n)
    cnt <= LAST);

  // R6: a load always restarts a full window
  p_load_full_r6: assert property (@(posedge clk) disable iff (!por_n)
    load |=> (cnt == LAST));

endmodule

// File: rtl/clkgen_startup_seq.sv
module clkgen_startup_seq
  import csq_pkg::*;
#(
  parameter int SYNC_LEN = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             sync_pin,
  input  logic             cfg_done,
  input  logic             pll_locked,
  output logic             cfg_start,
  output logic             pll_req,
  output logic             sync_out,
  output logic             out_en,
  output logic             out_mute,
  output logic             sysclk_vco,
  output logic             aon_osc_en
);

  ctl_t       ctl;
  logic       sw_rst_req;
  logic       sw_sync_req;
  logic       sync_req;
  logic       sync_done;
  logic       load_sync;
  seq_state_e st;
  seq_state_e nxt;
  logic       cfg_need;
  logic       cfg_issued;
  logic       auto_pend;

  csq_ctl_reg #(.W(CTL_W)) u_ctl (
    .clk        (clk),
    .por_n      (por_n),
    .ext_rst_n  (ext_rst_n),
    .wr         (ctl_wr),
    .wdata      (ctl_wdata),
    .ctl        (ctl),
    .sw_rst_req (sw_rst_req),
    .sw_sync_req(sw_sync_req)
  );

  csq_sync_req u_req (
    .clk   (clk),
    .por_n (por_n),
    .pin   (sync_pin),
    .sw_req(sw_sync_req),
    .req   (sync_req)
  );

  csq_sync_timer #(.LEN(SYNC_LEN)) u_tmr (
    .clk  (clk),
    .por_n(por_n),
    .load (load_sync),
    .done (sync_done)
  );

  always_comb begin
    nxt = st;
    if (!ext_rst_n || sw_rst_req) begin
      nxt = S_RESET;
    end else begin
      unique case (st)
        S_RESET:  nxt = cfg_need ? S_CONFIG : (ctl.autostart ? S_LOCK : S_HALT);
        S_CONFIG: if (cfg_done) nxt = ctl.autostart ? S_LOCK : S_HALT;
        S_HALT:   if (ctl.autostart) nxt = S_LOCK;
        S_LOCK:   if (pll_locked) nxt = (auto_pend && ctl.auto_sync) ? S_SYNC : S_RUN;
        S_SYNC: begin
          if (!pll_locked)    nxt = S_LOCK;
          else if (sync_done) nxt = S_RUN;
        end
        S_RUN: begin
          if (!pll_locked)    nxt = S_LOCK;
          else if (sync_req)  nxt = S_SYNC;
        end
        default: nxt = S_RESET;
      endcase
    end
  end

  assign load_sync = (nxt == S_SYNC) && (st != S_SYNC);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) st <= S_RESET;
    else        st <= nxt;
  end

  // Configuration status is outside the software reset domain.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          cfg_need <= 1'b1;
    else if (!ext_rst_n)                 cfg_need <= 1'b1;
    else if (st == S_CONFIG && cfg_done) cfg_need <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              cfg_issued <= 1'b0;
    else if (st == S_CONFIG) cfg_issued <= 1'b1;
    else                     cfg_issued <= 1'b0;
  end

  // Startup auto-sync applies to the first lock after any reset only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                         auto_pend <= 1'b1;
    else if (st == S_RESET)             auto_pend <= 1'b1;
    else if (st == S_LOCK && pll_locked) auto_pend <= 1'b0;
  end

  logic active;
  assign active     = (st == S_RUN) || (st == S_SYNC);
  assign cfg_start  = (st == S_CONFIG) && !cfg_issued;
  assign pll_req    = (st == S_LOCK) || active;
  assign sync_out   = (st == S_SYNC);
  assign out_en     = active;
  assign out_mute   = (st == S_SYNC) && ctl.sync_mute;
  assign sysclk_vco = active && !ctl.clk_hold;
  assign aon_osc_en = !sysclk_vco;

  // R1: the load strobe never lasts more than one cycle
  p_cfg_strobe_single_r1: assert property (@(posedge clk) disable iff (!por_n)
    cfg_start |=> !cfg_start);

  // R2: the pin reset forces the reset state
  p_pin_reset_r2: assert property (@(posedge clk) disable iff (!por_n)
    !ext_rst_n |=> (st == S_RESET) && !pll_req && !out_en);

  // R3: a software reset write forces the reset state
  p_soft_reset_r3: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst_req |=> (st == S_RESET));

  // R3: leaving reset with configuration already loaded gives no strobe
  p_soft_no_reload_r3: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_RESET && !cfg_need && ext_rst_n && !sw_rst_req) |=> !cfg_start);

  // R4: halt keeps the PLL and outputs idle
  p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_HALT) |-> (!pll_req && !out_en));

  // R7: mute only inside a sync event
  p_mute_in_sync_r7: assert property (@(posedge clk) disable iff (!por_n)
    out_mute |-> sync_out);

  // R8: clock hold keeps the always-on oscillator selected
  p_hold_keeps_aon_r8: assert property (@(posedge clk) disable iff (!por_n)
    ctl.clk_hold |-> (aon_osc_en && !sysclk_vco));

  // R10: no sync event can start from lock acquisition without lock
  p_no_early_sync_r10: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_LOCK && !pll_locked) |=> !sync_out);

  // R11: loss of lock in run drops the outputs next cycle
  p_lock_loss_r11: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_RUN && !pll_locked && ext_rst_n && !sw_rst_req) |=> (!out_en && pll_req));

endmodule

// File: tb/clkgen_startup_seq_tb.sv
module clkgen_startup_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SLEN       = 4;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       por_n, ext_rst_n, ctl_wr, sync_pin, cfg_done, pll_locked;
  logic [5:0] ctl_wdata;
  logic       cfg_start, pll_req, sync_out, out_en, out_mute, sysclk_vco, aon_osc_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_startup_seq #(.SYNC_LEN(SLEN)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .sync_pin(sync_pin), .cfg_done(cfg_done),
    .pll_locked(pll_locked), .cfg_start(cfg_start), .pll_req(pll_req),
    .sync_out(sync_out), .out_en(out_en), .out_mute(out_mute),
    .sysclk_vco(sysclk_vco), .aon_osc_en(aon_osc_en)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // control word: {rst_n, sync_n, auto_sync, mute, hold, autostart}
  function automatic logic [5:0] word(logic rn, logic sn, logic asy, logic mu,
                                      logic ho, logic au);
    return {rn, sn, asy, mu, ho, au};
  endfunction

  task automatic write(logic [5:0] w);
    ctl_wr = 1'b1; ctl_wdata = w;
    step();
    ctl_wr = 1'b0;
  endtask

  task automatic run_case(logic au, logic ho, logic mu, logic asy);
    // R2: pin reset and reload
    ext_rst_n = 1'b0;
    step();
    chk("R2", "pll_req in reset", pll_req, 1'b0);
    chk("R2", "out_en in reset", out_en, 1'b0);
    ext_rst_n = 1'b1;
    step();
    chk("R2", "cfg_start after pin reset", cfg_start, 1'b1);
    write(word(1, 1, asy, mu, ho, au));
    cfg_done = 1'b1;
    step();
    cfg_done = 1'b0;
    chk("R4", "pll_req after config", pll_req, au);
    if (!au) begin
      step();
      chk("R4", "halt holds", pll_req, 1'b0);
      write(word(1, 1, asy, mu, ho, 1));
      chk("R4", "halt one cycle after write", pll_req, 1'b0);
      step();
      chk("R4", "lock request after autostart", pll_req, 1'b1);
    end
    // R10: requests before first run are ignored
    sync_pin = 1'b1;
    step();
    sync_pin = 1'b0;
    write(word(1, 0, asy, mu, ho, 1));
    chk("R10", "no sync before run", sync_out, 1'b0);
    chk("R10", "outputs off before lock", out_en, 1'b0);
    pll_locked = 1'b1;
    step();
    chk("R5", "startup sync follows auto sync", sync_out, asy);
    chk("R5", "outputs enabled after lock", out_en, 1'b1);
    if (asy) begin
      for (int i = 0; i < SLEN; i++) begin
        chk("R6", "sync held", sync_out, 1'b1);
        chk("R7", "mute during sync", out_mute, mu);
        chk("R8", "vco select during sync", sysclk_vco, !ho);
        step();
      end
      chk("R6", "sync ends after SYNC_LEN", sync_out, 1'b0);
    end
    chk("R7", "no mute in run", out_mute, 1'b0);
    chk("R8", "vco select in run", sysclk_vco, !ho);
    chk("R8", "aon osc in run", aon_osc_en, ho);
    // R9: pin edge in run; R10: write during sync ignored
    sync_pin = 1'b1;
    step();
    chk("R9", "pin edge starts sync", sync_out, 1'b1);
    for (int i = 1; i < SLEN; i++) begin
      if (i == 1) ctl_wr = 1'b1;
      ctl_wdata = word(1, 0, asy, mu, ho, 1);
      step();
      ctl_wr = 1'b0;
      chk("R6", "pin sync held", sync_out, 1'b1);
    end
    step();
    chk("R10", "request during sync ignored", sync_out, 1'b0);
    step();
    chk("R10", "held pin no retrigger", sync_out, 1'b0);
    sync_pin = 1'b0;
    // R9: software sync in run
    write(word(1, 0, asy, mu, ho, 1));
    chk("R9", "software sync starts sync", sync_out, 1'b1);
    repeat (SLEN) step();
    chk("R6", "software sync length", sync_out, 1'b0);
    // R11: loss of lock
    pll_locked = 1'b0;
    step();
    chk("R11", "out_en off on lock loss", out_en, 1'b0);
    chk("R11", "pll_req held on lock loss", pll_req, 1'b1);
    chk("R8", "aon osc without lock", aon_osc_en, 1'b1);
    pll_locked = 1'b1;
    step();
    chk("R11", "relock goes to run", out_en, 1'b1);
    chk("R11", "relock without auto sync", sync_out, 1'b0);
    // R3: software reset keeps settings and skips reload
    write(word(0, 1, asy, mu, ho, 1));
    chk("R3", "soft reset idles pll", pll_req, 1'b0);
    chk("R3", "soft reset idles outputs", out_en, 1'b0);
    step();
    chk("R3", "no reload after soft reset", cfg_start, 1'b0);
    chk("R3", "lock request after soft reset", pll_req, 1'b1);
    step();
    chk("R5", "auto sync after soft reset", sync_out, asy);
    chk("R3", "settings kept by soft reset", sysclk_vco, !ho);
    pll_locked = 1'b0;
    step();
  endtask

  initial begin
    por_n = 1'b0; ext_rst_n = 1'b1; ctl_wr = 1'b0; ctl_wdata = '0;
    sync_pin = 1'b0; cfg_done = 1'b0; pll_locked = 1'b0;
    step(); step();
    chk("R1", "cfg_start in por", cfg_start, 1'b0);
    chk("R1", "pll_req in por", pll_req, 1'b0);
    chk("R1", "sync_out in por", sync_out, 1'b0);
    chk("R1", "out_en in por", out_en, 1'b0);
    chk("R1", "out_mute in por", out_mute, 1'b0);
    chk("R1", "sysclk_vco in por", sysclk_vco, 1'b0);
    chk("R1", "aon osc in por", aon_osc_en, 1'b1);
    por_n = 1'b1;
    step();
    chk("R1", "cfg_start after por", cfg_start, 1'b1);
    step();
    chk("R1", "cfg_start single cycle", cfg_start, 1'b0);
    // R12: defaults with no write
    cfg_done = 1'b1;
    step();
    cfg_done = 1'b0;
    chk("R12", "default autostart", pll_req, 1'b1);
    pll_locked = 1'b1;
    step();
    chk("R12", "default auto sync", sync_out, 1'b1);
    chk("R12", "default mute", out_mute, 1'b1);
    chk("R12", "default clock hold", sysclk_vco, 1'b1);
    pll_locked = 1'b0;
    step();
    chk("R11", "lock loss during sync", out_en, 1'b0);
    for (int c = 0; c < 16; c++) begin
      run_case(c[0], c[1], c[2], c[3]);
    end
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule